// File: doc/BRIEF.md
# Per-Cell NiMH Charge Phase Controller

This block steps a single nickel-metal-hydride cell through its charge lifecycle: standby, presence test, precharge, fast charge, cell test, top-off, maintenance and fault. It does not measure anything. It takes already-digitized flags as inputs: cell presence, voltage above 1.0 V and above 1.75 V, temperature inside the start window (0 to 45 °C), temperature past the 50 °C stop point, a termination pulse from an external negative-slope detector, a cell-test slot strobe with its fail verdict, undervoltage lockout, suspend, and a one-second tick. It produces the current phase, which the rate generator uses to pick the drive duty, and a two-bit status code for the indicator logic.

An internal tick counter times each phase. The precharge limit is a parameter. The fast-charge limit is a run-time input in seconds, clamped to a legal range. The top-off limit is half of the clamped fast limit. For a two-cell parallel charger, instantiate the block once per cell.

Top module: `nimh_phase_ctrl`

## Requirements
- R1: With `uvlo_i` high, the phase becomes STANDBY (0) on the next clock from any phase and the tick count is cleared. With `suspend_i` high and `uvlo_i` low, the phase becomes PRESENCE (1) and stays there while suspend is held. With both low, STANDBY moves to PRESENCE on the next clock.
- R2: In PRESENCE with a cell present and the over-voltage flag low, the cell goes to PRECHG (2) if below 1.0 V. It goes to FAST (3) if above 1.0 V with the start-window flag set, and otherwise it waits. Removing the cell in any phase from PRECHG to FAULT returns the machine to PRESENCE.
- R3: FAST is never entered while the start-window flag is low. In FAST or CTEST-free fast operation, the stop-temperature flag moves the cell to MAINT (6).
- R4: The over-voltage flag in PRECHG, FAST, CTEST (4), TOPOFF (5) or MAINT moves the cell to FAULT (7). This exit takes priority over every other exit except lockout, suspend and removal.
- R5: PRECHG exits to FAULT on the first clock after the tick count has reached `PRE_TMO_S`, unless the cell has already advanced to FAST.
- R6: FAST exits to TOPOFF on the slope-termination flag, or on the first clock after the count reaches the clamped fast limit. The count restarts at zero in TOPOFF.
- R7: TOPOFF exits to MAINT on the first clock after the count reaches half the clamped fast limit.
- R8: `fast_tmo_s_i` is clamped to the range 1800 to 36000 before use.
- R9: In FAST, a test-slot strobe moves the cell to CTEST for one clock. From CTEST, a set fail flag leads to FAULT, and otherwise the cell returns to FAST. The fast count keeps running across CTEST.
- R10: FAULT is held whatever the voltage, temperature, slope, test and tick inputs do. Only lockout, suspend or removal of the cell leaves it.
- R11: `status_o` is 0 in STANDBY and PRESENCE, 1 in PRECHG, FAST, CTEST and TOPOFF, 2 in MAINT, and 3 in FAULT. The reset value of `phase_o` is STANDBY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uvlo_i | input | 1 | Supply undervoltage lockout |
| suspend_i | input | 1 | Charge suspend request |
| tick_1s_i | input | 1 | One-cycle pulse per second |
| present_i | input | 1 | Cell detected in slot |
| v_min_ok_i | input | 1 | Cell voltage above 1.0 V |
| v_over_i | input | 1 | Cell voltage above 1.75 V |
| temp_start_ok_i | input | 1 | Temperature inside 0 to 45 °C |
| temp_stop_i | input | 1 | Temperature at or past 50 °C |
| slope_term_i | input | 1 | Negative-slope or flat termination from detector |
| test_slot_i | input | 1 | Cell-test slot strobe |
| test_fail_i | input | 1 | Loaded/unloaded difference above threshold |
| fast_tmo_s_i | input | TMR_W | Fast-charge timeout in seconds |
| phase_o | output | 3 | Current phase code |
| status_o | output | 2 | Indicator status code |

## Verification
The bench builds the block with `PRE_TMO_S` set to 20 and keeps the default fast range of 1800 to 36000. It drives the tick on every clock, so the precharge fault, the 1800-second fast expiry and the 900-second top-off expiry all arrive within a few thousand cycles, and their exact exit cycles can be checked. A fast limit of 10 checks the lower clamp. Thousands of biased random cycles then exercise the exit priorities, the sticky fault and the lockout and suspend paths against a phase model that the bench derives from the requirements.

// File: rtl/nimh_pkg.sv
package nimh_pkg;
  typedef enum logic [2:0] {
    PH_STANDBY  = 3'd0,
    PH_PRESENCE = 3'd1,
    PH_PRECHG   = 3'd2,
    PH_FAST     = 3'd3,
    PH_CTEST    = 3'd4,
    PH_TOPOFF   = 3'd5,
    PH_MAINT    = 3'd6,
    PH_FAULT    = 3'd7
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_CHARGING = 2'd1,
    ST_MAINT    = 2'd2,
    ST_FAULT    = 2'd3
  } status_e;
endpackage

// File: rtl/nimh_tmo_limit.sv
module nimh_tmo_limit #(
  parameter int unsigned FAST_MIN_S = 1800,
  parameter int unsigned FAST_MAX_S = 36000,
  parameter int unsigned TMR_W      = 16
) (
  input  logic [TMR_W-1:0] fast_tmo_s_i,
  output logic [TMR_W-1:0] fast_lim_o,
  output logic [TMR_W-1:0] top_lim_o
);
  localparam logic [TMR_W-1:0] LoLim = TMR_W'(FAST_MIN_S);
  localparam logic [TMR_W-1:0] HiLim = TMR_W'(FAST_MAX_S);

  always_comb begin
    if (fast_tmo_s_i < LoLim)      fast_lim_o = LoLim;
    else if (fast_tmo_s_i > HiLim) fast_lim_o = HiLim;
    else                           fast_lim_o = fast_tmo_s_i;
    top_lim_o = fast_lim_o >> 1;
  end
endmodule

// File: rtl/nimh_phase_timer.sv
module nimh_phase_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [TMR_W-1:0] cnt_o
);
  localparam logic [TMR_W-1:0] CntMax = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (clr_i)                    cnt_o <= '0;
    else if (en_i && cnt_o != CntMax)  cnt_o <= cnt_o + 1'b1;
  end

  AST_TMR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R1
  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(cnt_o)); // R9
endmodule

// File: rtl/nimh_status_enc.sv
module nimh_status_enc
  import nimh_pkg::*;
(
  input  phase_e  phase_i,
  output status_e status_o
);
  always_comb begin
    unique case (phase_i)
      PH_STANDBY, PH_PRESENCE:                 status_o = ST_IDLE;
      PH_PRECHG, PH_FAST, PH_CTEST, PH_TOPOFF: status_o = ST_CHARGING;
      PH_MAINT:                                status_o = ST_MAINT;
      default:                                 status_o = ST_FAULT;
    endcase
  end
endmodule

// File: rtl/nimh_phase_ctrl.sv
module nimh_phase_ctrl
  import nimh_pkg::*;
#(
  parameter int unsigned PRE_TMO_S  = 2040,
  parameter int unsigned FAST_MIN_S = 1800,
  parameter int unsigned FAST_MAX_S = 36000,
  parameter int unsigned TMR_W      = $clog2(FAST_MAX_S + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uvlo_i,
  input  logic             suspend_i,
  input  logic             tick_1s_i,
  input  logic             present_i,
  input  logic             v_min_ok_i,
  input  logic             v_over_i,
  input  logic             temp_start_ok_i,
  input  logic             temp_stop_i,
  input  logic             slope_term_i,
  input  logic             test_slot_i,
  input  logic             test_fail_i,
  input  logic [TMR_W-1:0] fast_tmo_s_i,
  output logic [2:0]       phase_o,
  output logic [1:0]       status_o
);
  localparam logic [TMR_W-1:0] PreLim = TMR_W'(PRE_TMO_S);

  phase_e           phase_q, phase_d;
  status_e          status;
  logic [TMR_W-1:0] cnt, fast_lim, top_lim;
  logic             tmr_clr, tmr_en, live, charging, fast_pair;

  nimh_tmo_limit #(
    .FAST_MIN_S(FAST_MIN_S), .FAST_MAX_S(FAST_MAX_S), .TMR_W(TMR_W)
  ) u_lim (
    .fast_tmo_s_i(fast_tmo_s_i), .fast_lim_o(fast_lim), .top_lim_o(top_lim)
  );

  // removal and lockout outrank every phase exit
  assign live     = !uvlo_i && !suspend_i && present_i;
  assign charging = phase_q inside {PH_PRECHG, PH_FAST, PH_CTEST, PH_TOPOFF, PH_MAINT};

  always_comb begin
    phase_d = phase_q;
    if (uvlo_i)                          phase_d = PH_STANDBY;
    else if (suspend_i)                  phase_d = PH_PRESENCE;
    else if (phase_q == PH_STANDBY)      phase_d = PH_PRESENCE;
    else if (phase_q == PH_PRESENCE) begin
      if (present_i && !v_over_i) begin
        if (!v_min_ok_i)                 phase_d = PH_PRECHG;
        else if (temp_start_ok_i)        phase_d = PH_FAST;
      end
    end
    else if (!present_i)                 phase_d = PH_PRESENCE;
    else if (charging && v_over_i)       phase_d = PH_FAULT;
    else begin
      unique case (phase_q)
        PH_PRECHG: begin
          if (cnt >= PreLim)                          phase_d = PH_FAULT;
          else if (v_min_ok_i && temp_start_ok_i)     phase_d = PH_FAST;
        end
        PH_FAST: begin
          if (temp_stop_i)                            phase_d = PH_MAINT;
          else if (slope_term_i || cnt >= fast_lim)   phase_d = PH_TOPOFF;
          else if (test_slot_i)                       phase_d = PH_CTEST;
        end
        PH_CTEST:  phase_d = test_fail_i ? PH_FAULT : PH_FAST;
        PH_TOPOFF: if (cnt >= top_lim)                phase_d = PH_MAINT;
        default: ;
      endcase
    end
  end

  // fast and cell test share one timing window
  assign fast_pair = (phase_q == PH_FAST && phase_d == PH_CTEST) ||
                     (phase_q == PH_CTEST && phase_d == PH_FAST);
  assign tmr_clr   = uvlo_i || suspend_i || (phase_d != phase_q && !fast_pair);
  assign tmr_en    = tick_1s_i &&
                     (phase_q inside {PH_PRECHG, PH_FAST, PH_CTEST, PH_TOPOFF});

  nimh_phase_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr), .en_i(tmr_en), .cnt_o(cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_STANDBY;
    else         phase_q <= phase_d;
  end

  nimh_status_enc u_stat (.phase_i(phase_q), .status_o(status));

  assign phase_o  = phase_q;
  assign status_o = status;

  AST_UVLO_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> phase_q == PH_STANDBY); // R1
  AST_SUSPEND_PRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i && !uvlo_i) |=> phase_q == PH_PRESENCE); // R1
  AST_FAST_NEEDS_TEMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q inside {PH_PRESENCE, PH_PRECHG} && !temp_start_ok_i) |=> phase_q != PH_FAST); // R3
  AST_OVERVOLT_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && charging && v_over_i) |=> phase_q == PH_FAULT); // R4
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && phase_q == PH_FAULT) |=> phase_q == PH_FAULT); // R10
  AST_CTEST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_CTEST |=> phase_q != PH_CTEST); // R9
endmodule

// File: tb/nimh_phase_ctrl_bench.sv
module nimh_phase_ctrl_bench;
  localparam int PRE = 20;
  localparam int TW  = 16;

  logic clk = 0, rst_n = 0;
  logic uvlo = 0, susp = 0, tick = 0, pres = 0, vmin = 0, vover = 0;
  logic tok = 0, tstop = 0, slope = 0, tslot = 0, tfail = 0;
  logic [TW-1:0] ftmo = 16'd1800;
  logic [2:0] phase;
  logic [1:0] status;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  nimh_phase_ctrl #(.PRE_TMO_S(PRE)) u_nimh_phase_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .uvlo_i(uvlo), .suspend_i(susp),
    .tick_1s_i(tick), .present_i(pres), .v_min_ok_i(vmin), .v_over_i(vover),
    .temp_start_ok_i(tok), .temp_stop_i(tstop), .slope_term_i(slope),
    .test_slot_i(tslot), .test_fail_i(tfail), .fast_tmo_s_i(ftmo),
    .phase_o(phase), .status_o(status));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cycles_to_leave(output int n);
    logic [2:0] start;
    start = phase;
    n = 0;
    do begin step(); n++; end while (phase == start && n < 50000);
  endtask

  function automatic int exp_status(input logic [2:0] p);
    case (p)
      3'd0, 3'd1: return 0;
      3'd6:       return 2;
      3'd7:       return 3;
      default:    return 1;
    endcase
  endfunction

  // phase model built from the requirements
  function automatic logic [2:0] mdl(input logic [2:0] p, input int t);
    logic chg;
    chg = p inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
    if (uvlo) return 3'd0;
    if (susp) return 3'd1;
    if (p == 3'd0) return 3'd1;
    if (p == 3'd1) begin
      if (pres && !vover) begin
        if (!vmin) return 3'd2;
        if (tok) return 3'd3;
      end
      return 3'd1;
    end
    if (!pres) return 3'd1;
    if (chg && vover) return 3'd7;
    case (p)
      3'd2: if (t >= PRE) return 3'd7; else if (vmin && tok) return 3'd3;
      3'd3: if (tstop) return 3'd6; else if (slope || t >= 1800) return 3'd5;
            else if (tslot) return 3'd4;
      3'd4: return tfail ? 3'd7 : 3'd3;
      3'd5: if (t >= 900) return 3'd6;
      default: ;
    endcase
    return p;
  endfunction

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [2:0] ep, np;
    int et;
    step(2);
    chk("R11 reset phase", phase, 0);
    chk("R11 reset status", status, 0);
    rst_n = 1;
    step();
    chk("R1 standby to presence", phase, 1);

    // precharge then timeout fault
    tick = 1; pres = 1; vmin = 0; tok = 1;
    step();
    chk("R2 low cell precharge", phase, 2);
    chk("R11 charging status", status, 1);
    cycles_to_leave(n);
    chk("R5 precharge timeout cycles", n, PRE + 1);
    chk("R5 precharge timeout fault", phase, 7);
    chk("R11 fault status", status, 3);

    // fault is sticky
    vmin = 1; slope = 1; tstop = 1; tslot = 1; vover = 1;
    step(10);
    chk("R10 fault held", phase, 7);
    vover = 0; slope = 0; tstop = 0; tslot = 0;
    pres = 0; step();
    chk("R2 removal leaves fault", phase, 1);

    // start window gates fast entry
    pres = 1; tok = 0; step(5);
    chk("R3 waits without temp window", phase, 1);
    tok = 1; step();
    chk("R2 good cell fast", phase, 3);
    slope = 1; step(); slope = 0;
    chk("R6 slope to topoff", phase, 5);
    ftmo = 16'd10;
    cycles_to_leave(n);
    chk("R7 R8 topoff half clamped", n, 901);
    chk("R7 topoff to maint", phase, 6);
    chk("R11 maint status", status, 2);
    vover = 1; step(); vover = 0;
    chk("R4 overvolt in maint", phase, 7);
    susp = 1; step(3);
    chk("R1 suspend holds presence", phase, 1);
    susp = 0; step();
    chk("R2 back to fast", phase, 3);

    // fast timeout
    ftmo = 16'd1800;
    cycles_to_leave(n);
    chk("R6 fast timeout cycles", n, 1801);
    chk("R6 fast timeout topoff", phase, 5);

    // cell test paths and temp stop
    pres = 0; step(); pres = 1; step();
    chk("R2 reinsert fast", phase, 3);
    tslot = 1; step(); tslot = 0;
    chk("R9 slot to cell test", phase, 4);
    tfail = 0; step();
    chk("R9 pass back to fast", phase, 3);
    tslot = 1; step(); tslot = 0; tfail = 1; step(); tfail = 0;
    chk("R9 fail to fault", phase, 7);
    pres = 0; step(); pres = 1; step();
    tstop = 1; step(); tstop = 0;
    chk("R3 stop temp to maint", phase, 6);
    uvlo = 1; step();
    chk("R1 uvlo standby", phase, 0);
    uvlo = 0; step();

    // biased random against the model
    void'($urandom(32'h5eed1));
    ep = phase; et = 0;
    for (int c = 0; c < 6000; c++) begin
      uvlo  = ($urandom % 300) == 0;
      susp  = ($urandom % 300) == 0;
      pres  = ($urandom % 120) != 0;
      vmin  = ($urandom % 10) < 8;
      vover = ($urandom % 60) == 0;
      tok   = ($urandom % 10) < 9;
      tstop = ($urandom % 40) == 0;
      slope = ($urandom % 50) == 0;
      tslot = ($urandom % 8) == 0;
      tfail = ($urandom % 10) == 0;
      tick  = $urandom % 2;
      np = mdl(ep, et);
      if (uvlo || susp || (np != ep && !((ep == 3 && np == 4) || (ep == 4 && np == 3))))
        et = 0;
      else if (tick && ep inside {3'd2, 3'd3, 3'd4, 3'd5})
        et++;
      ep = np;
      step();
      chk("RAND R2 R4 R10 phase", phase, ep);
      chk("RAND R11 status", status, exp_status(ep));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule